// File: doc/BRIEF.md
# Processor Trace Status and Data Nibble Port

This block turns instruction-completion events from a processor core into a real-time trace on two 4-bit outputs. The status output reports one code per clock: a plain code supplied by the core for an ordinary instruction, a fixed code for an instruction whose target address is captured (a taken indirect jump, for example), or zero when nothing completes or the core is held.

A captured instruction produces a group of nibbles. The group starts with a marker that announces how many address bytes follow, then carries the address nibbles with the least significant nibble first. The group is queued in a small nibble FIFO that drains one nibble per clock onto the data output. Because the data is queued, the status output can report the following instructions while an earlier address is still draining. A capture is accepted only when its whole group fits in the free FIFO space. Otherwise the block raises a stall request to the core, and the core holds the event until room appears.

A two-bit configuration input selects the captured address width: one, two, three or four bytes.

Top module: `trc_nibble_port`

## Requirements
- R1: While reset is asserted and at the first sample after it is released, `pst`, `ddata` and `core_stall` are all 0.
- R2: An accepted event with `ev_cap`=0 shows its `ev_code` on `pst` one clock after the edge that accepts it.
- R3: An accepted event with `ev_cap`=1 shows 0x5 on `pst` one clock after the edge that accepts it.
- R4: The first nibble of a capture group is a size marker equal to 0x8 + `cfg_addr_sel`. So 0x8 means 1 byte, 0x9 means 2 bytes, 0xA means 3 bytes and 0xB means 4 bytes.
- R5: After the marker come 2×(`cfg_addr_sel`+1) address nibbles, taken from `ev_addr` in the order [3:0], [7:4], [11:8], and so on upward.
- R6: When the FIFO holds data, `ddata` shows exactly one stored nibble per clock. Groups from successive captures follow each other with no gap.
- R7: When the FIFO was empty at a clock edge, `ddata` is 0x0 after that edge.
- R8: `core_stall` is high in the same cycle as `ev_valid`=1 and `ev_cap`=1 whenever DEPTH minus the current FIFO occupancy is less than the group length. A stalled event is not queued, `pst` is 0x0 after that edge, and the occupancy never exceeds DEPTH.
- R9: The `ddata` stream equals the concatenation of the groups of all accepted captures, in acceptance order, with no nibble lost or repeated.
- R10: An event with `ev_cap`=0 never stalls, even while captured data is still draining.
- R11: A cycle with `ev_valid`=0 gives `pst` = 0x0 after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | An instruction completes this cycle; held by the core while stalled |
| ev_cap | input | 1 | The instruction carries a target address to capture |
| ev_code | input | 4 | Status code reported for a non-capture instruction |
| ev_addr | input | 32 | Captured target address |
| cfg_addr_sel | input | 2 | Address width select: bytes = value + 1 |
| core_stall | output | 1 | Stall request to the core; the event is not taken this cycle |
| pst | output | 4 | Registered trace status nibble |
| ddata | output | 4 | Registered trace data nibble |

## Verification
`core_stall` is combinational and is due in the same cycle as the event. The bench checks it 1 ns after driving the inputs, before the next rising edge. `pst` and the `ddata` nibble popped at an edge are due immediately after that edge. The bench samples both on the following falling edge. A new marker therefore appears on `ddata` one edge after `pst` reports the capture when the FIFO starts out empty. The reference queue in the bench pops before it pushes at each modeled edge, which matches this one-edge lag.

// File: rtl/trc_pkg.sv
package trc_pkg;

  localparam int GROUP_MAX = 9;            // marker + eight address nibbles
  localparam logic [3:0] PST_IDLE = 4'h0;  // nothing completes, or core held
  localparam logic [3:0] PST_CAPT = 4'h5;  // taken transfer with captured target
  localparam logic [3:0] MARK_BASE = 4'h8; // marker for a one-byte address

  typedef logic [3:0] nib_t;
  typedef nib_t [GROUP_MAX-1:0] grp_t;

  // Marker announcing the address width of a group.
  function automatic nib_t size_marker(input logic [1:0] sel);
    return MARK_BASE + {2'b00, sel};
  endfunction

  // Nibbles in a group: one marker plus two per address byte.
  function automatic logic [3:0] group_len(input logic [1:0] sel);
    return 4'd3 + {1'b0, sel, 1'b0};
  endfunction

  // Address nibble k, counting up from the least significant one.
  function automatic nib_t addr_nibble(input logic [31:0] addr, input int k);
    return addr[4*k +: 4];
  endfunction

endpackage

// File: rtl/trc_pack.sv
module trc_pack
  import trc_pkg::*;
(
  input  logic [31:0] addr,
  input  logic [1:0]  sel,
  output grp_t        grp,
  output logic [3:0]  len
);

  for (genvar k = 0; k < GROUP_MAX; k++) begin : g_slot
    if (k == 0) begin : g_mark
      assign grp[k] = size_marker(sel);
    end else begin : g_addr
      assign grp[k] = addr_nibble(addr, k - 1);
    end
  end

  assign len = group_len(sel);

endmodule

// File: rtl/trc_status.sv
module trc_status
  import trc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
)(
  input  logic          ev_valid,
  input  logic          ev_cap,
  input  logic [3:0]    ev_code,
  input  logic [3:0]    need_len,
  input  logic [CW-1:0] occ,
  output logic          stall,
  output logic          accept,
  output logic [3:0]    pst_next
);

  logic [CW-1:0] free_slots;
  logic          short_room;

  assign free_slots = CW'(DEPTH) - occ;
  assign short_room = free_slots < CW'(need_len);
  assign stall      = ev_valid & ev_cap & short_room;
  assign accept     = ev_valid & ~stall;

  always_comb begin
    if (!accept)     pst_next = PST_IDLE;
    else if (ev_cap) pst_next = PST_CAPT;
    else             pst_next = ev_code;
  end

endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
  import trc_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [3:0]    push_len,
  input  grp_t          push_data,
  input  logic          pop_en,
  output nib_t          head,
  output logic [CW-1:0] occ
);

  nib_t          mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] add_n;
  logic [CW-1:0] sub_n;

  // A whole group is written in one clock, slot i at wptr+i.
  always_ff @(posedge clk) begin
    if (push_en) begin
      for (int i = 0; i < GROUP_MAX; i++) begin
        if (i < int'(push_len)) mem[wptr + AW'(i)] <= push_data[i];
      end
    end
  end

  assign add_n = push_en ? CW'(push_len) : '0;
  assign sub_n = pop_en ? CW'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push_en) wptr <= wptr + AW'(push_len);
      if (pop_en)  rptr <= rptr + AW'(1);
      occ <= occ + add_n - sub_n;
    end
  end

  assign head = mem[rptr];

endmodule

// File: rtl/trc_nibble_port.sv
module trc_nibble_port
  import trc_pkg::*;
#(
  parameter int DEPTH = 16   // power of two, at least GROUP_MAX
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  input  logic        ev_cap,
  input  logic [3:0]  ev_code,
  input  logic [31:0] ev_addr,
  input  logic [1:0]  cfg_addr_sel,
  output logic        core_stall,
  output logic [3:0]  pst,
  output logic [3:0]  ddata
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  grp_t          grp;
  logic [3:0]    grp_len;
  logic          accept;
  logic          fifo_push;
  logic          fifo_pop;
  logic [CW-1:0] fifo_occ;
  nib_t          fifo_head;
  logic [3:0]    pst_next;
  logic [3:0]    pst_q;
  logic [3:0]    ddata_q;

  trc_pack u_pack (
    .addr (ev_addr),
    .sel  (cfg_addr_sel),
    .grp  (grp),
    .len  (grp_len)
  );

  trc_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
    .ev_valid (ev_valid),
    .ev_cap   (ev_cap),
    .ev_code  (ev_code),
    .need_len (grp_len),
    .occ      (fifo_occ),
    .stall    (core_stall),
    .accept   (accept),
    .pst_next (pst_next)
  );

  assign fifo_push = accept & ev_cap;
  assign fifo_pop  = (fifo_occ != '0);

  trc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (fifo_push),
    .push_len  (grp_len),
    .push_data (grp),
    .pop_en    (fifo_pop),
    .head      (fifo_head),
    .occ       (fifo_occ)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst_q   <= PST_IDLE;
      ddata_q <= 4'h0;
    end else begin
      pst_q   <= pst_next;
      ddata_q <= fifo_pop ? fifo_head : 4'h0;
    end
  end

  assign pst   = pst_q;
  assign ddata = ddata_q;

endmodule

// File: rtl/trc_nibble_port_chk.sv
module trc_nibble_port_chk #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
)(
  input logic          clk,
  input logic          rst_n,
  input logic          ev_valid,
  input logic          ev_cap,
  input logic [3:0]    ev_code,
  input logic          core_stall,
  input logic [3:0]    pst,
  input logic [3:0]    ddata,
  input logic [CW-1:0] occ
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R8

  AST_STALL_PST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |=> (pst == 4'h0)); // R8

  AST_CAPTURE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_cap && !core_stall) |=> (pst == 4'h5)); // R3

  AST_PLAIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_cap) |=> (pst == $past(ev_code))); // R2

  AST_PLAIN_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_cap) |-> !core_stall); // R10

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |=> (ddata == 4'h0)); // R7

  AST_NOEVENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> (pst == 4'h0)); // R11

  AST_STALL_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    core_stall |-> (ev_valid && ev_cap)); // R8

endmodule

bind trc_nibble_port trc_nibble_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .ev_cap     (ev_cap),
  .ev_code    (ev_code),
  .core_stall (core_stall),
  .pst        (pst),
  .ddata      (ddata),
  .occ        (fifo_occ)
);

// File: tb/trc_nibble_port_bench.sv
`timescale 1ns/1ps
module trc_nibble_port_bench;

  localparam int DEPTH = 16;
  localparam int QN    = 8192;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid, ev_cap;
  logic [3:0]  ev_code;
  logic [31:0] ev_addr;
  logic [1:0]  cfg_addr_sel;
  logic        core_stall;
  logic [3:0]  pst, ddata;

  always #2.5 clk = ~clk;

  trc_nibble_port #(.DEPTH(DEPTH)) u_trc_nibble_port (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_cap(ev_cap),
    .ev_code(ev_code), .ev_addr(ev_addr), .cfg_addr_sel(cfg_addr_sel),
    .core_stall(core_stall), .pst(pst), .ddata(ddata)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [3:0] q [QN];
  int qh = 0, qt = 0, pushed_n = 0, popped_n = 0;
  logic [3:0] last_dd, last_pst;
  bit last_stall;

  function automatic int glen(input logic [1:0] s);
    return 1 + 2 * (int'(s) + 1);
  endfunction

  function automatic logic [3:0] gmark(input logic [1:0] s);
    return 4'(8 + int'(s));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One clock: entered and left on a falling edge.
  task automatic cycle(input bit v, input bit c, input logic [3:0] code,
                       input logic [31:0] a, input logic [1:0] s, output bit stalled);
    int occ;
    bit es, acc;
    logic [3:0] edd, ep;
    string ptag;
    ev_valid = v; ev_cap = c; ev_code = code; ev_addr = a; cfg_addr_sel = s;
    #1;
    occ = qt - qh;
    es  = v && c && (DEPTH - occ < glen(s));
    chk(core_stall === es, "R8 stall request", core_stall, es);
    last_stall = core_stall;
    stalled = es;
    acc = v && !es;
    edd = 4'h0;
    if (occ > 0) begin
      edd = q[qh % QN]; qh++; popped_n++;
    end
    if (acc && c) begin
      q[qt % QN] = gmark(s); qt++; pushed_n++;
      for (int k = 0; k < 2 * (int'(s) + 1); k++) begin
        q[qt % QN] = a[4*k +: 4]; qt++; pushed_n++;
      end
    end
    ep   = !acc ? 4'h0 : (c ? 4'h5 : code);
    ptag = !v ? "R11 idle status" : (es ? "R8 stall status" :
           (c ? "R3 capture status" : "R2 plain status"));
    @(negedge clk);
    last_pst = pst;
    last_dd  = ddata;
    chk(pst === ep, ptag, pst, ep);
    chk(ddata === edd, "R9 data stream", ddata, edd);
  endtask

  task automatic idle(input int n);
    bit st;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 4'h0, 32'h0, 2'd0, st);
  endtask

  task automatic drain();
    while (qt > qh) idle(1);
    idle(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit st;
    logic [31:0] a;
    logic [3:0] seq [6];
    int nst;
    bit hv, hc;
    logic [3:0] hcode;
    logic [31:0] haddr;
    logic [1:0] hsel;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ev_valid = 0; ev_cap = 0; ev_code = 0; ev_addr = 0; cfg_addr_sel = 0;
    repeat (3) @(negedge clk);
    chk(pst === 4'h0, "R1 reset pst", pst, 0);
    chk(ddata === 4'h0, "R1 reset ddata", ddata, 0);
    chk(core_stall === 1'b0, "R1 reset stall", core_stall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pst === 4'h0 && ddata === 4'h0, "R1 after release", {pst, ddata}, 0);

    // R4 / R5 / R7: every address width on an empty FIFO
    for (int s = 0; s < 4; s++) begin
      a = 32'h8765_4321 ^ (32'h1111_1111 * s);
      cycle(1'b1, 1'b1, 4'h0, a, 2'(s), st);
      chk(last_pst === 4'h5, "R3 capture code", last_pst, 5);
      idle(1);
      chk(last_dd === gmark(2'(s)), "R4 marker", last_dd, gmark(2'(s)));
      for (int k = 0; k < 2 * (s + 1); k++) begin
        idle(1);
        chk(last_dd === a[4*k +: 4], "R5 nibble order", last_dd, a[4*k +: 4]);
      end
      idle(1);
      chk(last_dd === 4'h0, "R7 empty idle", last_dd, 0);
    end

    // R6: two back-to-back one-byte captures stream without a gap
    cycle(1'b1, 1'b1, 4'h0, 32'h0000_00A7, 2'd0, st);
    cycle(1'b1, 1'b1, 4'h0, 32'h0000_003C, 2'd0, st);
    chk(last_dd === 4'h8, "R6 first marker", last_dd, 8);
    for (int i = 0; i < 6; i++) begin
      idle(1);
      seq[i] = last_dd;
    end
    chk(seq[0] === 4'h7 && seq[1] === 4'hA, "R6 first group", {seq[0], seq[1]}, 8'h7A);
    chk(seq[2] === 4'h8, "R6 second marker contiguous", seq[2], 8);
    chk(seq[3] === 4'hC && seq[4] === 4'h3, "R6 second group", {seq[3], seq[4]}, 8'hC3);
    chk(seq[5] === 4'h0, "R7 idle after groups", seq[5], 0);

    // R10: plain instructions run ahead while data drains
    cycle(1'b1, 1'b1, 4'h0, 32'hDEAD_BEEF, 2'd3, st);
    foreach (seq[i]) begin
      if (i < 5) begin
        cycle(1'b1, 1'b0, 4'(i + 10), 32'h0, 2'd3, st);
        chk(!last_stall && last_pst === 4'(i + 10), "R10 status runs ahead",
            {last_stall, last_pst}, 4'(i + 10));
      end
    end
    drain();

    // R8: second four-byte capture waits two cycles for room
    cycle(1'b1, 1'b1, 4'h0, 32'h0123_4567, 2'd3, st);
    nst = 0;
    st = 1'b1;
    while (st) begin
      cycle(1'b1, 1'b1, 4'h0, 32'h89AB_CDEF, 2'd3, st);
      if (st) begin
        nst++;
        chk(last_pst === 4'h0, "R8 stalled status zero", last_pst, 0);
      end
    end
    chk(nst == 2, "R8 stall length", nst, 2);
    drain();

    // Random traffic; a stalled event is held by the core
    st = 1'b0;
    hv = 0; hc = 0; hcode = 0; haddr = 0; hsel = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!st) begin
        hv    = ($urandom_range(0, 3) != 0);
        hc    = ($urandom_range(0, 2) == 0);
        hcode = 4'($urandom_range(1, 15));
        haddr = $urandom;
        hsel  = 2'($urandom_range(0, 3));
      end
      cycle(hv, hc, hcode, haddr, hsel, st);
    end
    drain();
    chk(last_dd === 4'h0, "R7 idle after drain", last_dd, 0);
    chk(pushed_n == popped_n, "R9 no loss or duplicate", popped_n, pushed_n);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule